// File: doc/BRIEF.md
# Paired-Byte ISA to IDE Data Steering

This block connects an 8-bit host I/O bus to a 16-bit ATA/IDE device. It decodes one or two 16-port I/O windows and turns each host strobe into IDE chip selects, a register index and read/write strobes. It also drives the enables for the two IDE data lanes.

The IDE data register is 16 bits wide, while the host moves one byte at a time, low byte first. For that register the block joins two consecutive byte accesses into one device transfer. A write to window offset 0 only captures the byte in a holding register, and no device cycle takes place. The write to offset 1 then launches the 16-bit device write, with the held byte on the low lane and the live host byte on the high lane. Reads run the other way round. A read at offset 0 performs the device read, returns the low lane and keeps the high lane. A read at offset 1 then returns the kept byte without touching the device. Host word I/O instructions therefore work in both directions.

A second window can drive its own pair of chip selects. A swap input exchanges which window drives which physical channel.

Top module: `pairedByteMux`

## Requirements
- R1: With hostAen high, or with an address outside every window, the block starts no IDE cycle: both strobes stay high, all chip selects stay high, no lane or host enable is set, and the held bytes do not change.
- R2: A write at window offset 0 stores the host byte in the write holding register. It asserts no chip select and no IDE strobe, and drives neither IDE lane.
- R3: A write at window offset 1 asserts CS0 of the hit channel, register index 0 and DIOW low. It drives ideDataOut = {host byte, held byte} with both lane enables set.
- R4: A write at offsets 2 to 7 asserts CS0 and DIOW low, with register index = offset[2:0]. The host byte goes on the low lane only (ideHiOe low, upper lane 0).
- R5: A write at offsets 8 to 15 asserts CS1 instead of CS0, with register index = offset[2:0] and low-lane-only data.
- R6: A read at offset 0 asserts CS0, register index 0 and DIOR low. It returns ideDataIn[7:0] on hostDataOut with hostDataOe high, and captures ideDataIn[15:8] at the clock edge.
- R7: A read at offset 1 starts no IDE cycle (no chip select, DIOR high) and returns the byte captured by the last offset-0 read.
- R8: A read at offsets 2 to 15 asserts DIOR low with the chip select chosen by offset[3] and register index offset[2:0], and returns ideDataIn[7:0].
- R9: Window k drives chip-select bit k (bit 0 for the 300h window, bit 1 for the 310h window). With chanSwap high the two bits exchange. The offset-0 holding register is shared by both windows.
- R10: While rstN is low every IDE strobe and chip select is inactive. Reset clears both held bytes to 0.
- R11: An access with IOR and IOW both low is treated as no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| hostAddr | input | 10 | Host I/O address |
| hostAen | input | 1 | DMA address enable, high blocks decode |
| hostIowN | input | 1 | Host I/O write strobe, active low |
| hostIorN | input | 1 | Host I/O read strobe, active low |
| hostDataIn | input | 8 | Byte written by the host |
| hostDataOut | output | 8 | Byte returned to the host |
| hostDataOe | output | 1 | Host data bus drive enable |
| chanSwap | input | 1 | Exchange window-to-channel mapping |
| ideDataIn | input | 16 | Word read from the device |
| ideDataOut | output | 16 | Word driven to the device |
| ideLoOe | output | 1 | Low lane (D0-D7) drive enable |
| ideHiOe | output | 1 | High lane (D8-D15) drive enable |
| ideCs0N | output | 2 | Command-block chip select per channel, active low |
| ideCs1N | output | 2 | Control-block chip select per channel, active low |
| ideAddr | output | 3 | Device register index |
| ideDiowN | output | 1 | Device write strobe, active low |
| ideDiorN | output | 1 | Device read strobe, active low |

## Verification
Two things can collide in the same cycle. One is a host strobe that hits a window while the DMA enable is high. The other is both host strobes low on a valid port. The bench drives an offset-0 write and an offset-0 read with hostAen high. It then reads the held bytes back through offset-1 accesses and shows they are unchanged. It also drives a cycle with IOR and IOW low together and checks that every IDE strobe and chip select stays idle. A shared holding register that feeds either channel is checked by latching through the second window and pairing on that window's offset 1.

// File: rtl/pairedByteMux_pkg.sv
package pairedByteMux_pkg;

  // Lane steering commands from the decoder to the data path.
  typedef struct packed {
    logic latchLo;      // capture host byte into write holding register
    logic holdHi;       // capture device high lane into read holding register
    logic driveLo;      // drive device low lane
    logic driveHi;      // drive device high lane (paired write)
    logic hostDrive;    // drive host data bus
    logic hostFromHold; // host byte comes from read holding register
  } laneCtl_t;

endpackage

// File: rtl/byteMuxCtrl.sv
module byteMuxCtrl
  import pairedByteMux_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NCH = 2,
  parameter logic [NCH*ADDR_W-1:0] BASES = {10'h310, 10'h300}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostAen,
  input  logic              hostIowN,
  input  logic              hostIorN,
  input  logic              chanSwap,
  output laneCtl_t          laneCtl,
  output logic [NCH-1:0]    ideCs0N,
  output logic [NCH-1:0]    ideCs1N,
  output logic [2:0]        ideAddr,
  output logic              ideDiowN,
  output logic              ideDiorN
);

  localparam int OFF_W = 4;
  localparam int CH_W = 1;
  localparam logic SWAP_OK = 1'(NCH > 1);

  logic [NCH-1:0] winHit;
  logic [CH_W-1:0] hitIdx, physIdx;
  logic anyHit;
  logic [OFF_W-1:0] offset;
  logic wrAcc, rdAcc, isBaseWr, isPairWr, isPairRd, ideCycle;

  for (genvar c = 0; c < NCH; c++) begin : g_win
    assign winHit[c] = !hostAen &&
      (hostAddr[ADDR_W-1:OFF_W] == BASES[c*ADDR_W+OFF_W +: ADDR_W-OFF_W]);
  end

  always_comb begin
    hitIdx = '0;
    anyHit = 1'b0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (winHit[c]) begin
        hitIdx = CH_W'(c);
        anyHit = 1'b1;
      end
    end
  end

  assign physIdx = hitIdx ^ CH_W'(SWAP_OK & chanSwap);
  assign offset = hostAddr[OFF_W-1:0];

  assign wrAcc = rstN && anyHit && !hostIowN && hostIorN;
  assign rdAcc = rstN && anyHit && !hostIorN && hostIowN;
  assign isBaseWr = wrAcc && (offset == '0);
  assign isPairWr = wrAcc && (offset == OFF_W'(1));
  assign isPairRd = rdAcc && (offset == OFF_W'(1));
  assign ideCycle = (wrAcc || rdAcc) && !isBaseWr && !isPairRd;

  always_comb begin
    ideCs0N = '1;
    ideCs1N = '1;
    if (ideCycle) begin
      if (offset[OFF_W-1]) ideCs1N[physIdx] = 1'b0;
      else                 ideCs0N[physIdx] = 1'b0;
    end
  end

  assign ideAddr  = (ideCycle && !isPairWr) ? offset[2:0] : 3'd0;
  assign ideDiowN = !(ideCycle && wrAcc);
  assign ideDiorN = !(ideCycle && rdAcc);

  always_comb begin
    laneCtl = '0;
    laneCtl.latchLo      = isBaseWr;
    laneCtl.holdHi       = rdAcc && (offset == '0);
    laneCtl.driveLo      = wrAcc && !isBaseWr;
    laneCtl.driveHi      = isPairWr;
    laneCtl.hostDrive    = rdAcc;
    laneCtl.hostFromHold = isPairRd;
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!ideDiowN && !ideDiorN));

  // R1
  aen_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAen |-> (ideDiowN && ideDiorN && (&ideCs0N) && (&ideCs1N)));

  // R3
  pair_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneCtl.driveHi |-> (!ideDiowN && ideAddr == 3'd0 && !(&ideCs0N)));

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~{ideCs0N, ideCs1N}));

  // R7
  pair_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneCtl.hostFromHold |-> (ideDiorN && (&ideCs0N) && (&ideCs1N)));

endmodule

// File: rtl/byteMuxPath.sv
module byteMuxPath
  import pairedByteMux_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneCtl_t            laneCtl,
  input  logic [BYTE_W-1:0]   hostDataIn,
  input  logic [2*BYTE_W-1:0] ideDataIn,
  output logic [BYTE_W-1:0]   hostDataOut,
  output logic                hostDataOe,
  output logic [2*BYTE_W-1:0] ideDataOut,
  output logic                ideLoOe,
  output logic                ideHiOe
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] wrLatch, rdHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLatch <= '0;
      rdHold  <= '0;
    end else begin
      if (laneCtl.latchLo) wrLatch <= hostDataIn;
      if (laneCtl.holdHi)  rdHold  <= ideDataIn[WORD_W-1:BYTE_W];
    end
  end

  always_comb begin
    ideDataOut = '0;
    if (laneCtl.driveLo) ideDataOut[BYTE_W-1:0] = laneCtl.driveHi ? wrLatch : hostDataIn;
    if (laneCtl.driveHi) ideDataOut[WORD_W-1:BYTE_W] = hostDataIn;
  end

  assign ideLoOe = laneCtl.driveLo;
  assign ideHiOe = laneCtl.driveHi;
  assign hostDataOe = laneCtl.hostDrive;
  assign hostDataOut = !laneCtl.hostDrive ? '0 :
                       laneCtl.hostFromHold ? rdHold : ideDataIn[BYTE_W-1:0];

  // R6
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneCtl.holdHi |=> (rdHold == $past(ideDataIn[WORD_W-1:BYTE_W])));

  // R2
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !laneCtl.latchLo |=> $stable(wrLatch));

  // R4
  hi_lane_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    ideHiOe |-> (ideLoOe && !hostDataOe));

endmodule

// File: rtl/pairedByteMux.sv
module pairedByteMux
  import pairedByteMux_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int NCH = 2,
  parameter logic [NCH*ADDR_W-1:0] BASES = {10'h310, 10'h300}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                hostAen,
  input  logic                hostIowN,
  input  logic                hostIorN,
  input  logic [BYTE_W-1:0]   hostDataIn,
  output logic [BYTE_W-1:0]   hostDataOut,
  output logic                hostDataOe,
  input  logic                chanSwap,
  input  logic [2*BYTE_W-1:0] ideDataIn,
  output logic [2*BYTE_W-1:0] ideDataOut,
  output logic                ideLoOe,
  output logic                ideHiOe,
  output logic [NCH-1:0]      ideCs0N,
  output logic [NCH-1:0]      ideCs1N,
  output logic [2:0]          ideAddr,
  output logic                ideDiowN,
  output logic                ideDiorN
);

  laneCtl_t laneCtl;

  byteMuxCtrl #(.ADDR_W(ADDR_W), .NCH(NCH), .BASES(BASES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostAen(hostAen),
    .hostIowN(hostIowN), .hostIorN(hostIorN), .chanSwap(chanSwap),
    .laneCtl(laneCtl), .ideCs0N(ideCs0N), .ideCs1N(ideCs1N),
    .ideAddr(ideAddr), .ideDiowN(ideDiowN), .ideDiorN(ideDiorN)
  );

  byteMuxPath #(.BYTE_W(BYTE_W)) u_path (
    .clk(clk), .rstN(rstN), .laneCtl(laneCtl), .hostDataIn(hostDataIn),
    .ideDataIn(ideDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .ideDataOut(ideDataOut), .ideLoOe(ideLoOe), .ideHiOe(ideHiOe)
  );

endmodule

// File: tb/pairedByteMux_tb.sv
`timescale 1ns/1ps
module pairedByteMux_tb;

  typedef struct packed {
    logic [9:0]  a;
    logic        w, r, aen, sw;
    logic [7:0]  hd;
    logic [15:0] ii;
    logic        dw, dr;
    logic [1:0]  c0, c1;
    logic [2:0]  ea;
    logic [15:0] eo;
    logic        lo, hi, ho;
    logic [7:0]  eh;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{10'h300,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 idle
    '{10'h300,1'b1,1'b0,1'b0,1'b0,8'hA5,16'h0000, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd2},  // R2 latch A5
    '{10'h301,1'b1,1'b0,1'b0,1'b0,8'h3C,16'h0000, 1'b0,1'b1,2'b10,2'b11,3'd0,16'h3CA5,1'b1,1'b1,1'b0,8'h00,4'd3},  // R3 pair
    '{10'h307,1'b1,1'b0,1'b0,1'b0,8'hEC,16'h0000, 1'b0,1'b1,2'b10,2'b11,3'd7,16'h00EC,1'b1,1'b0,1'b0,8'h00,4'd4},  // R4
    '{10'h30E,1'b1,1'b0,1'b0,1'b0,8'h04,16'h0000, 1'b0,1'b1,2'b11,2'b10,3'd6,16'h0004,1'b1,1'b0,1'b0,8'h00,4'd5},  // R5
    '{10'h300,1'b0,1'b1,1'b0,1'b0,8'h00,16'hBEEF, 1'b1,1'b0,2'b10,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b1,8'hEF,4'd6},  // R6
    '{10'h301,1'b0,1'b1,1'b0,1'b0,8'h00,16'h1234, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b1,8'hBE,4'd7},  // R7
    '{10'h307,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0050, 1'b1,1'b0,2'b10,2'b11,3'd7,16'h0000,1'b0,1'b0,1'b1,8'h50,4'd8},  // R8
    '{10'h30F,1'b0,1'b1,1'b0,1'b0,8'h00,16'h77AA, 1'b1,1'b0,2'b11,2'b10,3'd7,16'h0000,1'b0,1'b0,1'b1,8'hAA,4'd8},  // R8
    '{10'h313,1'b1,1'b0,1'b0,1'b0,8'h11,16'h0000, 1'b0,1'b1,2'b01,2'b11,3'd3,16'h0011,1'b1,1'b0,1'b0,8'h00,4'd9},  // R9
    '{10'h313,1'b1,1'b0,1'b0,1'b1,8'h11,16'h0000, 1'b0,1'b1,2'b10,2'b11,3'd3,16'h0011,1'b1,1'b0,1'b0,8'h00,4'd9},  // R9 swap
    '{10'h303,1'b1,1'b0,1'b0,1'b1,8'h22,16'h0000, 1'b0,1'b1,2'b01,2'b11,3'd3,16'h0022,1'b1,1'b0,1'b0,8'h00,4'd9},  // R9 swap
    '{10'h303,1'b1,1'b0,1'b1,1'b0,8'h22,16'h0000, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 aen
    '{10'h320,1'b0,1'b1,1'b0,1'b0,8'h00,16'h5555, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 outside
    '{10'h2F5,1'b1,1'b0,1'b0,1'b0,8'h66,16'h0000, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 outside
    '{10'h302,1'b1,1'b1,1'b0,1'b0,8'h66,16'h1111, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd11}, // R11
    '{10'h301,1'b1,1'b0,1'b0,1'b0,8'h77,16'h0000, 1'b0,1'b1,2'b10,2'b11,3'd0,16'h77A5,1'b1,1'b1,1'b0,8'h00,4'd3},  // R3 latch kept
    '{10'h310,1'b1,1'b0,1'b0,1'b0,8'h5A,16'h0000, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd2},  // R2 second window
    '{10'h311,1'b1,1'b0,1'b0,1'b0,8'hC3,16'h0000, 1'b0,1'b1,2'b01,2'b11,3'd0,16'hC35A,1'b1,1'b1,1'b0,8'h00,4'd3},  // R3 chan1
    '{10'h300,1'b0,1'b1,1'b1,1'b0,8'h00,16'hFFFF, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 aen read
    '{10'h301,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0000, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b1,8'hBE,4'd1},  // R1 hold kept
    '{10'h300,1'b1,1'b0,1'b1,1'b0,8'hFF,16'h0000, 1'b1,1'b1,2'b11,2'b11,3'd0,16'h0000,1'b0,1'b0,1'b0,8'h00,4'd1},  // R1 aen write
    '{10'h301,1'b1,1'b0,1'b0,1'b0,8'h01,16'h0000, 1'b0,1'b1,2'b10,2'b11,3'd0,16'h015A,1'b1,1'b1,1'b0,8'h00,4'd1}   // R1 latch kept
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] hostAddr = '0;
  logic hostAen = 1'b0, hostIowN = 1'b1, hostIorN = 1'b1, chanSwap = 1'b0;
  logic [7:0] hostDataIn = '0;
  logic [15:0] ideDataIn = '0;
  logic [7:0] hostDataOut;
  logic hostDataOe, ideLoOe, ideHiOe, ideDiowN, ideDiorN;
  logic [15:0] ideDataOut;
  logic [1:0] ideCs0N, ideCs1N;
  logic [2:0] ideAddr;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pairedByteMux u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostAen(hostAen),
    .hostIowN(hostIowN), .hostIorN(hostIorN), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .chanSwap(chanSwap),
    .ideDataIn(ideDataIn), .ideDataOut(ideDataOut), .ideLoOe(ideLoOe),
    .ideHiOe(ideHiOe), .ideCs0N(ideCs0N), .ideCs1N(ideCs1N),
    .ideAddr(ideAddr), .ideDiowN(ideDiowN), .ideDiorN(ideDiorN)
  );

  task automatic runVec(input vec_t v, input int idx);
    logic [35:0] got, exp;
    @(negedge clk);
    hostAddr = v.a; hostIowN = !v.w; hostIorN = !v.r;
    hostAen = v.aen; chanSwap = v.sw; hostDataIn = v.hd; ideDataIn = v.ii;
    #1;
    got = {ideDiowN, ideDiorN, ideCs0N, ideCs1N, ideAddr, ideDataOut,
           ideLoOe, ideHiOe, hostDataOe, hostDataOut};
    exp = {v.dw, v.dr, v.c0, v.c1, v.ea, v.eo, v.lo, v.hi, v.ho, v.eh};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d step %0d: actual=%h expected=%h", v.rq, idx, got, exp);
    end
  endtask

  function automatic vec_t idleVec(input logic [9:0] a, input logic w, input logic r,
                                   input logic [7:0] hd, input logic [3:0] rq);
    vec_t v;
    v = '0;
    v.a = a; v.w = w; v.r = r; v.hd = hd;
    v.dw = 1'b1; v.dr = 1'b1; v.c0 = 2'b11; v.c1 = 2'b11; v.rq = rq;
    return v;
  endfunction

  initial begin
    vec_t v;
    // R10: strobes inactive while reset is held, even with a pairing write
    runVec(idleVec(10'h301, 1'b1, 1'b0, 8'h99, 4'd10), 100);
    runVec(idleVec(10'h300, 1'b0, 1'b1, 8'h00, 4'd10), 101);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R10: reset mid-run clears both held bytes
    @(negedge clk);
    rstN = 1'b0;
    runVec(idleVec(10'h307, 1'b1, 1'b0, 8'h12, 4'd10), 102);
    @(negedge clk);
    rstN = 1'b1;
    v = idleVec(10'h301, 1'b1, 1'b0, 8'h99, 4'd10);
    v.dw = 1'b0; v.c0 = 2'b10; v.eo = 16'h9900; v.lo = 1'b1; v.hi = 1'b1;
    runVec(v, 103);
    v = idleVec(10'h301, 1'b0, 1'b1, 8'h00, 4'd10);
    v.ho = 1'b1; v.eh = 8'h00;
    runVec(v, 104);

    // R6 / R7: second pairing read through window 1 replaces the held byte
    v = idleVec(10'h310, 1'b0, 1'b1, 8'h00, 4'd6);
    v.ii = 16'h4D21; v.dr = 1'b0; v.c0 = 2'b01; v.ho = 1'b1; v.eh = 8'h21;
    runVec(v, 105);
    v = idleVec(10'h301, 1'b0, 1'b1, 8'h00, 4'd7);
    v.ho = 1'b1; v.eh = 8'h4D;
    runVec(v, 106);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule